// File: doc/BRIEF.md
# Warp Branch Divergence Mask Stack

This block keeps the control state of one warp whose lanes share a single program counter. It holds the current PC and an active-lane mask. Only lanes whose mask bit is set may run. When the pipeline reports a conditional branch, the block ANDs the per-lane taken vector with the active mask. If every active lane agrees, the block simply redirects the PC. If the lanes disagree, it runs the taken lanes first. It keeps two stack entries for later: one resumes the not-taken lanes at the fall-through address, and one restores the pre-branch mask at the reconvergence address.

The pipeline reports a reconvergence event with the PC it has reached. If that PC matches the reconvergence address held in the top entry, the entry is popped and its PC and mask become current. The second path therefore starts only after the first has fully finished, and the full mask returns once both paths are done. Ordinary sequential progress is reported with a separate advance event carrying the next PC. The stack depth is a parameter. A divergent branch that finds fewer than two free slots is refused, and a sticky error flag is raised.

Top module: `simt_mask_stack`

## Requirements
- R1: After a synchronous active-low reset, `active_mask` is all ones, `cur_pc` equals `RESET_PC`, the stack is empty and `ovf_flag` is 0.
- R2: An advance event (`seq_valid`) with no branch or reconvergence event in the same cycle loads `seq_pc` into `cur_pc` on the next cycle and leaves `active_mask` unchanged.
- R3: A branch whose effective taken set (`br_taken_mask & active_mask`) equals `active_mask` sets `cur_pc` to `br_target_pc`, keeps the mask and pushes nothing.
- R4: A branch whose effective taken set is zero sets `cur_pc` to `br_fall_pc`, keeps the mask and pushes nothing.
- R5: A divergent branch (effective set neither zero nor equal to the mask) with room sets `cur_pc` to `br_target_pc` and `active_mask` to the effective taken set, and pushes two entries.
- R6: The first reconvergence event matching the top entry after a divergent branch sets `cur_pc` to that branch's fall-through PC and `active_mask` to the pre-branch mask with the taken lanes cleared.
- R7: The next matching reconvergence event sets `cur_pc` to the reconvergence PC and restores the mask held before the branch.
- R8: A reconvergence event is ignored (PC and mask unchanged) when the stack is empty or when `rc_pc` differs from the top entry's reconvergence PC.
- R9: A divergent branch that finds fewer than two free slots leaves PC, mask and stack unchanged and sets `ovf_flag`, which stays set until reset.
- R10: In one cycle a branch event takes precedence over a reconvergence event, and a reconvergence event (matching or not) takes precedence over an advance event; the lower events are dropped.
- R11: Taken bits of inactive lanes have no effect, and a branch never turns on a lane that was inactive before it.
- R12: Nested divergent branches unwind last-in first-out: the inner pair of entries pops before the outer pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Branch event this cycle |
| br_taken_mask | input | NUM_LANES | Per-lane branch outcome, 1 = taken |
| br_target_pc | input | PC_W | Branch target address |
| br_fall_pc | input | PC_W | Fall-through address |
| br_reconv_pc | input | PC_W | Address where both paths rejoin |
| rc_valid | input | 1 | Reconvergence-reached event this cycle |
| rc_pc | input | PC_W | PC at which the reconvergence event occurred |
| seq_valid | input | 1 | Sequential advance event this cycle |
| seq_pc | input | PC_W | Next PC for a sequential advance |
| cur_pc | output | PC_W | Current warp PC |
| active_mask | output | NUM_LANES | Lanes allowed to run, 1 = active |
| ovf_flag | output | 1 | Sticky stack-overflow error |

## Verification
The bench sweeps every taken pattern of a four-lane warp, first alone and then nested under every divergent outer pattern. Expected masks come from AND and AND-NOT of the two patterns, and each unwinding step is compared. The events that can share a cycle are a branch and a reconvergence report, or a reconvergence report and a plain advance. The bench drives these pairs together with distinct addresses, so that `cur_pc` shows which event won. This includes a non-matching reconvergence report paired with an advance, where the PC must not move. Overflow is provoked by nesting until a third divergent level finds a full four-entry stack. The bench then checks that PC and mask are frozen and that the flag survives the whole unwind.

// File: rtl/simt_stack_pkg.sv
// Package: shared types of the warp divergence mask stack.
// Assumes: nothing beyond IEEE 1800-2017.
package simt_stack_pkg;
    // Classification of a branch against the current active mask.
    typedef enum logic [1:0] {
        BK_FALL  = 2'd0,   // no active lane taken
        BK_JUMP  = 2'd1,   // every active lane taken
        BK_SPLIT = 2'd2    // active lanes disagree
    } br_kind_e;
endpackage

// File: rtl/simt_branch_split.sv
// Module: simt_branch_split
// Splits the active mask by a per-lane taken vector and classifies the
// branch as fall-through, uniform jump or divergent split.
// Assumes: active_mask is never zero while the warp runs.
module simt_branch_split
    import simt_stack_pkg::*;
#(
    parameter int NUM_LANES = 32
) (
    input  logic [NUM_LANES-1:0] active_mask,
    input  logic [NUM_LANES-1:0] taken_mask,
    output logic [NUM_LANES-1:0] eff_taken,
    output logic [NUM_LANES-1:0] eff_not_taken,
    output br_kind_e             kind
);
    // Mask off inactive lanes, then classify the result.
    always_comb begin
        eff_taken     = taken_mask & active_mask;
        eff_not_taken = active_mask & ~taken_mask;
        if (eff_taken == '0)
            kind = BK_FALL;
        else if (eff_taken == active_mask)
            kind = BK_JUMP;
        else
            kind = BK_SPLIT;
    end
endmodule

// File: rtl/simt_reconv_lifo.sv
// Module: simt_reconv_lifo
// LIFO of (pc, mask, reconvergence pc) entries. A push writes two entries
// at once: the restore entry below and the deferred-path entry on top.
// A pop removes one entry.
// Assumes: the caller pushes only when room2 is high, pops only when
// empty is low, and never does both in one cycle. DEPTH >= 2.
module simt_reconv_lifo #(
    parameter int NUM_LANES = 32,
    parameter int PC_W      = 32,
    parameter int DEPTH     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push2,
    input  logic [PC_W-1:0]      lo_pc,
    input  logic [NUM_LANES-1:0] lo_mask,
    input  logic [PC_W-1:0]      hi_pc,
    input  logic [NUM_LANES-1:0] hi_mask,
    input  logic [PC_W-1:0]      ent_rpc,
    input  logic                 pop,
    output logic                 empty,
    output logic                 room2,
    output logic [PC_W-1:0]      top_pc,
    output logic [NUM_LANES-1:0] top_mask,
    output logic [PC_W-1:0]      top_rpc
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]     cnt_q;
    logic [PC_W-1:0]      s_pc   [DEPTH];
    logic [NUM_LANES-1:0] s_mask [DEPTH];
    logic [PC_W-1:0]      s_rpc  [DEPTH];

    // Occupancy counter: +2 on push, -1 on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push2)
            cnt_q <= cnt_q + CNT_W'(2);
        else if (pop)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // One register slot per stack level.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Capture the restore entry at the old count and the deferred entry just above it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_pc[i]   <= '0;
                s_mask[i] <= '0;
                s_rpc[i]  <= '0;
            end else if (push2 && int'(cnt_q) == i) begin
                s_pc[i]   <= lo_pc;
                s_mask[i] <= lo_mask;
                s_rpc[i]  <= ent_rpc;
            end else if (push2 && int'(cnt_q) + 1 == i) begin
                s_pc[i]   <= hi_pc;
                s_mask[i] <= hi_mask;
                s_rpc[i]  <= ent_rpc;
            end
        end
    end

    // Select the top-of-stack entry and derive occupancy flags.
    always_comb begin
        top_pc   = '0;
        top_mask = '0;
        top_rpc  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(cnt_q) == i + 1) begin
                top_pc   = s_pc[i];
                top_mask = s_mask[i];
                top_rpc  = s_rpc[i];
            end
        end
        empty = (cnt_q == '0);
        room2 = (int'(cnt_q) + 2 <= DEPTH);
    end
endmodule

// File: rtl/simt_mask_stack.sv
// Module: simt_mask_stack (top)
// Keeps PC and active-lane mask for one warp. Redirects on uniform branches,
// serialises divergent branches through a LIFO and restores the mask when the
// reconvergence PC on top of the stack is reached.
// Assumes: at most one instruction event matters per cycle; priority is
// branch, then reconvergence, then sequential advance.
module simt_mask_stack
    import simt_stack_pkg::*;
#(
    parameter int NUM_LANES = 32,
    parameter int PC_W      = 32,
    parameter int DEPTH     = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 br_valid,
    input  logic [NUM_LANES-1:0] br_taken_mask,
    input  logic [PC_W-1:0]      br_target_pc,
    input  logic [PC_W-1:0]      br_fall_pc,
    input  logic [PC_W-1:0]      br_reconv_pc,
    input  logic                 rc_valid,
    input  logic [PC_W-1:0]      rc_pc,
    input  logic                 seq_valid,
    input  logic [PC_W-1:0]      seq_pc,
    output logic [PC_W-1:0]      cur_pc,
    output logic [NUM_LANES-1:0] active_mask,
    output logic                 ovf_flag
);
    logic [PC_W-1:0]      pc_q, pc_d;
    logic [NUM_LANES-1:0] mask_q, mask_d;
    logic                 ovf_q;

    logic [NUM_LANES-1:0] eff_taken, eff_not_taken;
    br_kind_e             kind;

    logic                 st_empty, st_room2, do_push, do_pop, ovf_set;
    logic [PC_W-1:0]      top_pc, top_rpc;
    logic [NUM_LANES-1:0] top_mask;

    simt_branch_split #(.NUM_LANES(NUM_LANES)) split_i (
        .active_mask   (mask_q),
        .taken_mask    (br_taken_mask),
        .eff_taken     (eff_taken),
        .eff_not_taken (eff_not_taken),
        .kind          (kind)
    );

    simt_reconv_lifo #(.NUM_LANES(NUM_LANES), .PC_W(PC_W), .DEPTH(DEPTH)) lifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push2    (do_push),
        .lo_pc    (br_reconv_pc),
        .lo_mask  (mask_q),
        .hi_pc    (br_fall_pc),
        .hi_mask  (eff_not_taken),
        .ent_rpc  (br_reconv_pc),
        .pop      (do_pop),
        .empty    (st_empty),
        .room2    (st_room2),
        .top_pc   (top_pc),
        .top_mask (top_mask),
        .top_rpc  (top_rpc)
    );

    // Decide push, pop and overflow from the prioritised events.
    always_comb begin
        do_push = br_valid && (kind == BK_SPLIT) && st_room2;
        ovf_set = br_valid && (kind == BK_SPLIT) && !st_room2;
        do_pop  = !br_valid && rc_valid && !st_empty && (rc_pc == top_rpc);
    end

    // Next PC and mask: branch first, then reconvergence, then advance.
    always_comb begin
        pc_d   = pc_q;
        mask_d = mask_q;
        if (br_valid) begin
            unique case (kind)
                BK_FALL: pc_d = br_fall_pc;
                BK_JUMP: pc_d = br_target_pc;
                default: begin
                    if (st_room2) begin
                        pc_d   = br_target_pc;
                        mask_d = eff_taken;
                    end
                end
            endcase
        end else if (rc_valid) begin
            if (do_pop) begin
                pc_d   = top_pc;
                mask_d = top_mask;
            end
        end else if (seq_valid) begin
            pc_d = seq_pc;
        end
    end

    // Warp state registers and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            mask_q <= '1;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            if (ovf_set)
                ovf_q <= 1'b1;
        end
    end

    assign cur_pc      = pc_q;
    assign active_mask = mask_q;
    assign ovf_flag    = ovf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
// Module: simt_mask_stack_chk
// Port-level temporal checks for simt_mask_stack, attached by bind.
// Assumes: the same parameters as the bound instance.
module simt_mask_stack_chk #(
    parameter int NUM_LANES = 32,
    parameter int PC_W      = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 br_valid,
    input logic [NUM_LANES-1:0] br_taken_mask,
    input logic [PC_W-1:0]      br_target_pc,
    input logic                 rc_valid,
    input logic                 seq_valid,
    input logic [PC_W-1:0]      seq_pc,
    input logic [PC_W-1:0]      cur_pc,
    input logic [NUM_LANES-1:0] active_mask,
    input logic                 ovf_flag
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (active_mask == {NUM_LANES{1'b1}}) && !ovf_flag);

    p_seq_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && !br_valid && !rc_valid) |=> (cur_pc == $past(seq_pc)) && $stable(active_mask));

    p_uniform_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && ((br_taken_mask & active_mask) == active_mask))
            |=> (cur_pc == $past(br_target_pc)) && $stable(active_mask));

    p_mask_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_no_new_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> ((active_mask & ~$past(active_mask)) == '0));
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.NUM_LANES(NUM_LANES), .PC_W(PC_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .br_valid      (br_valid),
    .br_taken_mask (br_taken_mask),
    .br_target_pc  (br_target_pc),
    .rc_valid      (rc_valid),
    .seq_valid     (seq_valid),
    .seq_pc        (seq_pc),
    .cur_pc        (cur_pc),
    .active_mask   (active_mask),
    .ovf_flag      (ovf_flag)
);

// File: tb/simt_mask_stack_tb_top.sv
// Bench for simt_mask_stack: four lanes, depth four, exhaustive taken sweeps.
module simt_mask_stack_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 4;
    localparam int PW = 16;
    localparam int D  = 4;
    localparam logic [PW-1:0] RPC = 16'h0040;
    localparam logic [L-1:0]  F   = 4'hF;

    logic clk = 1'b0;
    logic rst_n;
    logic br_valid, rc_valid, seq_valid;
    logic [L-1:0]  br_taken_mask;
    logic [PW-1:0] br_target_pc, br_fall_pc, br_reconv_pc, rc_pc, seq_pc;
    logic [PW-1:0] cur_pc;
    logic [L-1:0]  active_mask;
    logic ovf_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_mask_stack #(.NUM_LANES(L), .PC_W(PW), .DEPTH(D), .RESET_PC(RPC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_taken_mask(br_taken_mask),
        .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc), .br_reconv_pc(br_reconv_pc),
        .rc_valid(rc_valid), .rc_pc(rc_pc),
        .seq_valid(seq_valid), .seq_pc(seq_pc),
        .cur_pc(cur_pc), .active_mask(active_mask), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [PW-1:0] epc, input logic [L-1:0] emask);
        chk({tag, " pc"}, 32'(cur_pc), 32'(epc));
        chk({tag, " mask"}, 32'(active_mask), 32'(emask));
    endtask

    task automatic idle();
        br_valid = 0; rc_valid = 0; seq_valid = 0;
        br_taken_mask = '0; br_target_pc = '0; br_fall_pc = '0; br_reconv_pc = '0;
        rc_pc = '0; seq_pc = '0;
    endtask

    // Drive one event at a negedge, release at the next negedge (result visible there).
    task automatic do_br(input logic [L-1:0] t, input int tg, input int ft, input int rp);
        @(negedge clk);
        br_valid = 1; br_taken_mask = t;
        br_target_pc = PW'(tg); br_fall_pc = PW'(ft); br_reconv_pc = PW'(rp);
        @(negedge clk);
        idle();
    endtask

    task automatic do_rc(input int p);
        @(negedge clk);
        rc_valid = 1; rc_pc = PW'(p);
        @(negedge clk);
        idle();
    endtask

    task automatic do_seq(input int p);
        @(negedge clk);
        seq_valid = 1; seq_pc = PW'(p);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        do_reset();
        // R1: reset state
        chk_state("R1 reset", RPC, F);
        chk("R1 ovf", 32'(ovf_flag), 0);
        do_rc(RPC);
        chk_state("R1 stack empty (R8)", RPC, F);

        // R2: sequential advance
        do_seq(16'h0044);
        chk_state("R2 seq", 16'h0044, F);

        // Single-level sweep over every taken pattern: R3 R4 R5 R6 R7 R8
        for (int t = 0; t < 16; t++) begin
            int tg = 100 + t, ft = 200 + t, rp = 300 + t;
            do_br(L'(t), tg, ft, rp);
            if (t == 0) begin
                chk_state("R4 all fall", PW'(ft), F);
            end else if (t == 15) begin
                chk_state("R3 uniform", PW'(tg), F);
            end else begin
                chk_state("R5 split", PW'(tg), L'(t));
                do_rc(rp + 1);
                chk_state("R8 mismatch", PW'(tg), L'(t));
                do_rc(rp);
                chk_state("R6 first pop", PW'(ft), F & ~L'(t));
                do_rc(rp);
                chk_state("R7 second pop", PW'(rp), F);
            end
            do_rc(rp);
            chk_state("R8 empty ignore", cur_pc, F);
        end

        // Nested sweep: outer divergent t1, inner every t2. R11 R12
        for (int t1 = 1; t1 < 15; t1++) begin
            for (int t2 = 0; t2 < 16; t2++) begin
                logic [L-1:0] m1, e2;
                m1 = L'(t1);
                e2 = L'(t2) & m1;
                do_br(m1, 1000, 1100, 1200);
                chk_state("R5 outer", 16'd1000, m1);
                do_br(L'(t2), 2000 + t2, 2100 + t2, 2200 + t2);
                if (e2 == 0) begin
                    chk_state("R11 inner fall", PW'(2100 + t2), m1);
                end else if (e2 == m1) begin
                    chk_state("R11 inner jump", PW'(2000 + t2), m1);
                end else begin
                    chk_state("R11 inner split", PW'(2000 + t2), e2);
                    do_rc(1200);
                    chk_state("R12 outer rpc not on top", PW'(2000 + t2), e2);
                    do_rc(2200 + t2);
                    chk_state("R12 inner pop1", PW'(2100 + t2), m1 & ~L'(t2));
                    do_rc(2200 + t2);
                    chk_state("R12 inner pop2", PW'(2200 + t2), m1);
                end
                do_rc(1200);
                chk_state("R12 outer pop1", 16'd1100, F & ~m1);
                do_rc(1200);
                chk_state("R12 outer pop2", 16'd1200, F);
            end
        end

        // R10: priorities
        @(negedge clk);
        br_valid = 1; br_taken_mask = F; br_target_pc = 16'd500;
        rc_valid = 1; rc_pc = 16'd1200; seq_valid = 1; seq_pc = 16'd600;
        @(negedge clk);
        idle();
        chk_state("R10 br over rc/seq", 16'd500, F);
        do_br(4'b0011, 510, 520, 530);
        @(negedge clk);
        rc_valid = 1; rc_pc = 16'd530; seq_valid = 1; seq_pc = 16'd700;
        @(negedge clk);
        idle();
        chk_state("R10 rc over seq", 16'd520, 4'b1100);
        @(negedge clk);
        rc_valid = 1; rc_pc = 16'd999; seq_valid = 1; seq_pc = 16'd800;
        @(negedge clk);
        idle();
        chk_state("R10 mismatched rc blocks seq", 16'd520, 4'b1100);
        do_rc(530);
        chk_state("R10 unwind", 16'd530, F);

        // R9: overflow on third nesting level
        do_br(4'b0111, 10, 11, 12);
        do_br(4'b0011, 20, 21, 22);
        chk_state("R9 full", 16'd20, 4'b0011);
        chk("R9 no ovf yet", 32'(ovf_flag), 0);
        do_br(4'b0001, 30, 31, 32);
        chk_state("R9 refused", 16'd20, 4'b0011);
        chk("R9 ovf set", 32'(ovf_flag), 1);
        do_rc(22);
        chk_state("R9 unwind1", 16'd21, 4'b0100);
        do_rc(22);
        chk_state("R9 unwind2", 16'd22, 4'b0111);
        do_rc(12);
        chk_state("R9 unwind3", 16'd11, 4'b1000);
        do_rc(12);
        chk_state("R9 unwind4", 16'd12, F);
        chk("R9 ovf sticky", 32'(ovf_flag), 1);
        do_reset();
        chk("R1 ovf cleared by reset", 32'(ovf_flag), 0);
        chk_state("R1 after reset", RPC, F);

        finish_run();
    end
endmodule